// File: doc/BRIEF.md
# Scatter-gather ring chunk descriptor generator

This block sits between a stream packer and a memory writer in a stream-to-memory transfer engine. The packer hands it one record per burst: a word count (one word is 32 bytes) and a flag saying the burst closes a packet. For each record the block works out where in host memory the burst goes. It then hands a chunk descriptor to the writer. The host buffer is a ring of equally sized pages scattered through memory. Their 64-bit base addresses sit in an on-chip table that software fills.

A second ring, with a fixed number of slots, holds one location record per finished packet. A record gives the ring position (page and word offset) of the packet's first word and of its last word. The host releases pages and packet slots by moving two indices. The block marks a burst as overrun, and tells the writer to drop its data, when that burst would land in a page or slot the host still holds. It exports the page being written, the packet slot in progress and a sticky overrun flag.

Bursts must never cross a page boundary, because the packer already cuts them there. One burst is handled at a time. A new record is taken only after the writer has accepted the previous descriptor and, if one was raised, its location record.

Top module: `sgc_chunk_gen`

## Requirements
- R1: After a synchronous active-high reset: `brst_ready`=1, `dsc_valid`=0, `loc_valid`=0, `cur_page`=0, `cur_pkt`=0 and `ovr_flag`=0.
- R2: The descriptor address is the table entry of the target page plus 32 times the target word offset. Table entries are written one at a time through `tbl_we`/`tbl_idx`/`tbl_data`.
- R3: A burst that ends exactly at the last word of a page leaves the page full. The next accepted burst then starts at offset 0 of the following page, and the page after page `pg_cnt`-1 is page 0. `cur_page` shows the page last written and updates on the edge that accepts a burst.
- R4: `dsc_bytes` is 32 times `brst_words`. `dsc_page` is the target page, `dsc_pkt` is `cur_pkt` at acceptance, and `dsc_eop` copies `brst_last`.
- R5: If the current page is full and the following page index equals `host_page`, the burst is overrun. `dsc_ovr`=1, the write position and `cur_page` do not move, and no location record is raised even when the burst closes a packet.
- R6: If (`cur_pkt`+1) modulo PKT_SLOTS equals `host_pkt`, every burst is overrun (`dsc_ovr`=1), no record is raised and `cur_pkt` holds.
- R7: `ovr_flag` rises on the edge that accepts an overrun burst and stays high until reset.
- R8: A raised descriptor or location record keeps its fields stable until its own ready is seen high. `brst_ready` stays low while either one is outstanding.
- R9: A non-overrun burst with `brst_last`=1 raises a location record. `loc_addr` = `loc_base` + 16 × `cur_pkt`. The start position is that of the packet's first non-dropped burst, and the end position is the page and offset of its last word. `cur_pkt` advances by one (modulo PKT_SLOTS) on the edge that completes the later of the two handshakes, and not before.
- R10: Once the host moves `host_page` off the blocking value, the next burst is written normally at offset 0 of the following page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| tbl_we | input | 1 | write strobe for the page table |
| tbl_idx | input | PW | table entry to write |
| tbl_data | input | 64 | page base address |
| pg_cnt | input | CW | number of pages in use (2..NBUFS) |
| loc_base | input | 64 | base address of the location-record page |
| host_page | input | PW | first page still held by the host |
| host_pkt | input | KW | first packet slot still held by the host |
| brst_valid | input | 1 | burst record present |
| brst_ready | output | 1 | block can take a burst record |
| brst_words | input | LW | burst length in 32-byte words (1..MAX_BURST) |
| brst_last | input | 1 | burst closes its packet |
| dsc_valid | output | 1 | descriptor present |
| dsc_ready | input | 1 | writer takes the descriptor |
| dsc_addr | output | 64 | destination address |
| dsc_bytes | output | BW | length in bytes |
| dsc_page | output | PW | target page |
| dsc_pkt | output | KW | packet slot |
| dsc_ovr | output | 1 | overrun: drop this burst's data |
| dsc_eop | output | 1 | burst closes its packet |
| loc_valid | output | 1 | location record present |
| loc_ready | input | 1 | writer takes the location record |
| loc_addr | output | 64 | address of the record in the location page |
| loc_start_page | output | PW | page of the packet's first word |
| loc_start_off | output | OW | word offset of the packet's first word |
| loc_end_page | output | PW | page of the packet's last word |
| loc_end_off | output | OW | word offset of the packet's last word |
| cur_page | output | PW | page last written |
| cur_pkt | output | KW | packet slot in progress |
| ovr_flag | output | 1 | sticky overrun status |

## Verification
Every descriptor field and `cur_page` is due one edge after the edge that accepts a burst. The bench drives each record at a falling edge, lets one rising edge take it, and samples at the next falling edge. `cur_pkt` and `brst_ready` change on the same edge as the later of the two writer handshakes. So the bench holds each ready low for a random number of cycles and checks at every falling edge in between that the fields hold, that `brst_ready` stays low and that `cur_pkt` has not moved. It checks the new values at the first falling edge after both handshakes are done.

// File: rtl/sgc_pkg.sv
`timescale 1ns/1ps
package sgc_pkg;
    localparam int ADDR_W     = 64;
    localparam int WORD_BYTES = 32;
    localparam int LOC_BYTES  = 16;
    localparam int WORD_SH    = $clog2(WORD_BYTES);
    localparam int LOC_SH     = $clog2(LOC_BYTES);

    typedef enum logic [1:0] {
        REC_NONE = 2'd0,
        REC_DATA = 2'd1,
        REC_BOTH = 2'd2
    } rec_kind_e;

    function automatic logic [31:0] ring_next(input logic [31:0] idx,
                                              input logic [31:0] cnt);
        logic [31:0] inc;
        inc = idx + 32'd1;
        return (inc >= cnt) ? 32'd0 : inc;
    endfunction

    function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base,
                                                    input logic [31:0] off);
        return base + (ADDR_W'(off) << WORD_SH);
    endfunction
endpackage

// File: rtl/sgc_page_table.sv
`timescale 1ns/1ps
module sgc_page_table #(
    parameter int NBUFS = 512,
    parameter int AW    = 64,
    localparam int PW   = $clog2(NBUFS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] widx,
    input  logic [AW-1:0] wdata,
    input  logic [PW-1:0] ridx,
    output logic [AW-1:0] rdata
);
    logic [AW-1:0] entry [NBUFS];

    for (genvar g = 0; g < NBUFS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (we && (widx == PW'(g)))
                entry[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NBUFS; i++)
            if (ridx == PW'(i))
                rdata = entry[i];
    end
endmodule

// File: rtl/sgc_ring_track.sv
`timescale 1ns/1ps
module sgc_ring_track
    import sgc_pkg::*;
#(
    parameter int NBUFS      = 512,
    parameter int PAGE_WORDS = 65536,
    parameter int PKT_SLOTS  = 65536,
    parameter int MAX_BURST  = 64,
    localparam int PW = $clog2(NBUFS),
    localparam int CW = $clog2(NBUFS + 1),
    localparam int OW = $clog2(PAGE_WORDS),
    localparam int KW = $clog2(PKT_SLOTS),
    localparam int LW = $clog2(MAX_BURST + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] pg_cnt,
    input  logic [PW-1:0] host_page,
    input  logic [KW-1:0] host_pkt,
    input  logic [KW-1:0] cur_pkt,
    input  logic [LW-1:0] words,
    input  logic          last,
    input  logic          fire,
    output logic [PW-1:0] tgt_page,
    output logic [OW-1:0] tgt_off,
    output logic          ovr,
    output logic [PW-1:0] start_page,
    output logic [OW-1:0] start_off,
    output logic [OW-1:0] end_off,
    output logic [PW-1:0] cur_page
);
    typedef struct packed {
        logic [PW-1:0] page;
        logic [OW-1:0] off;
    } pos_t;

    logic [PW-1:0] wp_q;
    logic [OW-1:0] off_q;
    logic          full_q;
    logic          in_pkt_q;
    pos_t          start_q;

    logic [PW-1:0] nxt_page;
    logic [KW-1:0] nxt_pkt;
    logic          pg_block, pk_block;
    logic [31:0]   fill;

    always_comb begin
        nxt_page = PW'(ring_next(32'(wp_q), 32'(pg_cnt)));
        nxt_pkt  = KW'(ring_next(32'(cur_pkt), 32'(PKT_SLOTS)));
        pg_block = full_q && (nxt_page == host_page);
        pk_block = (nxt_pkt == host_pkt);
        ovr      = pg_block || pk_block;
        tgt_page = full_q ? nxt_page : wp_q;
        tgt_off  = full_q ? '0 : off_q;
        fill     = 32'(tgt_off) + 32'(words);
        end_off  = OW'(fill - 32'd1);
        start_page = in_pkt_q ? start_q.page : tgt_page;
        start_off  = in_pkt_q ? start_q.off  : tgt_off;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q     <= '0;
            off_q    <= '0;
            full_q   <= 1'b0;
            in_pkt_q <= 1'b0;
            start_q  <= '0;
        end else if (fire) begin
            if (!ovr) begin
                wp_q <= tgt_page;
                if (fill >= 32'(PAGE_WORDS)) begin
                    off_q  <= '0;
                    full_q <= 1'b1;
                end else begin
                    off_q  <= OW'(fill);
                    full_q <= 1'b0;
                end
                if (!in_pkt_q)
                    start_q <= '{page: tgt_page, off: tgt_off};
                in_pkt_q <= !last;
            end else if (last) begin
                in_pkt_q <= 1'b0;
            end
        end
    end

    assign cur_page = wp_q;

    assert_page_range_R3: assert property (@(posedge clk) disable iff (rst)
        fire && (pg_cnt != '0) |=> (32'(cur_page) < 32'($past(pg_cnt))));
    assert_hold_pos_R5: assert property (@(posedge clk) disable iff (rst)
        fire && ovr |=> $stable(cur_page));
endmodule

// File: rtl/sgc_out_stage.sv
`timescale 1ns/1ps
module sgc_out_stage
    import sgc_pkg::*;
#(
    parameter int PW = 9,
    parameter int OW = 16,
    parameter int KW = 16,
    parameter int BW = 12,
    parameter int PKT_SLOTS = 65536
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BW-1:0]     in_bytes,
    input  logic [PW-1:0]     in_page,
    input  logic              in_ovr,
    input  logic              in_eop,
    input  logic [PW-1:0]     in_sp,
    input  logic [OW-1:0]     in_so,
    input  logic [OW-1:0]     in_eo,
    input  logic [ADDR_W-1:0] loc_base,
    output logic              brst_ready,
    output logic              dsc_valid,
    input  logic              dsc_ready,
    output logic [ADDR_W-1:0] dsc_addr,
    output logic [BW-1:0]     dsc_bytes,
    output logic [PW-1:0]     dsc_page,
    output logic [KW-1:0]     dsc_pkt,
    output logic              dsc_ovr,
    output logic              dsc_eop,
    output logic              loc_valid,
    input  logic              loc_ready,
    output logic [ADDR_W-1:0] loc_addr,
    output logic [PW-1:0]     loc_start_page,
    output logic [OW-1:0]     loc_start_off,
    output logic [PW-1:0]     loc_end_page,
    output logic [OW-1:0]     loc_end_off,
    output logic [KW-1:0]     cur_pkt,
    output logic              ovr_flag
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BW-1:0]     bytes;
        logic [PW-1:0]     page;
        logic [KW-1:0]     pkt;
        logic              ovr;
        logic              eop;
    } desc_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [PW-1:0]     sp;
        logic [OW-1:0]     so;
        logic [PW-1:0]     ep;
        logic [OW-1:0]     eo;
    } loc_t;

    desc_t     dsc_q;
    loc_t      loc_q;
    logic      dsc_v, loc_v;
    rec_kind_e kind_q;
    logic [KW-1:0] pkt_q;
    logic      ovr_q;
    logic      dsc_v_n, loc_v_n, rec_pend;

    assign dsc_v_n  = dsc_v && !dsc_ready;
    assign loc_v_n  = loc_v && !loc_ready;
    assign rec_pend = (kind_q == REC_BOTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            dsc_v  <= 1'b0;
            loc_v  <= 1'b0;
            kind_q <= REC_NONE;
            pkt_q  <= '0;
            ovr_q  <= 1'b0;
            dsc_q  <= '0;
            loc_q  <= '0;
        end else if (fire) begin
            dsc_v  <= 1'b1;
            loc_v  <= in_eop && !in_ovr;
            kind_q <= (in_eop && !in_ovr) ? REC_BOTH : REC_DATA;
            dsc_q  <= '{addr: in_addr, bytes: in_bytes, page: in_page,
                        pkt: pkt_q, ovr: in_ovr, eop: in_eop};
            loc_q  <= '{addr: loc_base + (ADDR_W'(pkt_q) << LOC_SH),
                        sp: in_sp, so: in_so, ep: in_page, eo: in_eo};
            if (in_ovr)
                ovr_q <= 1'b1;
        end else begin
            dsc_v <= dsc_v_n;
            loc_v <= loc_v_n;
            if (!dsc_v_n && !loc_v_n) begin
                kind_q <= REC_NONE;
                if (rec_pend)
                    pkt_q <= KW'(ring_next(32'(pkt_q), 32'(PKT_SLOTS)));
            end
        end
    end

    assign brst_ready     = !dsc_v && !loc_v;
    assign dsc_valid      = dsc_v;
    assign dsc_addr       = dsc_q.addr;
    assign dsc_bytes      = dsc_q.bytes;
    assign dsc_page       = dsc_q.page;
    assign dsc_pkt        = dsc_q.pkt;
    assign dsc_ovr        = dsc_q.ovr;
    assign dsc_eop        = dsc_q.eop;
    assign loc_valid      = loc_v;
    assign loc_addr       = loc_q.addr;
    assign loc_start_page = loc_q.sp;
    assign loc_start_off  = loc_q.so;
    assign loc_end_page   = loc_q.ep;
    assign loc_end_off    = loc_q.eo;
    assign cur_pkt        = pkt_q;
    assign ovr_flag       = ovr_q;

    assert_dsc_hold_R8: assert property (@(posedge clk) disable iff (rst)
        dsc_v && !dsc_ready |=> dsc_v && $stable(dsc_q));
    assert_loc_hold_R8: assert property (@(posedge clk) disable iff (rst)
        loc_v && !loc_ready |=> loc_v && $stable(loc_q));
    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ovr_flag |=> ovr_flag);
    assert_no_rec_on_ovr_R5: assert property (@(posedge clk) disable iff (rst)
        dsc_valid && dsc_ovr |-> !loc_valid);
    assert_pkt_after_rec_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_pkt) |-> $past(rec_pend));
endmodule

// File: rtl/sgc_chunk_gen.sv
`timescale 1ns/1ps
module sgc_chunk_gen
    import sgc_pkg::*;
#(
    parameter int NBUFS      = 512,
    parameter int PAGE_BYTES = 2097152,
    parameter int PKT_SLOTS  = 65536,
    parameter int MAX_BURST  = 64,
    localparam int PAGE_WORDS = PAGE_BYTES / WORD_BYTES,
    localparam int PW = $clog2(NBUFS),
    localparam int CW = $clog2(NBUFS + 1),
    localparam int OW = $clog2(PAGE_WORDS),
    localparam int KW = $clog2(PKT_SLOTS),
    localparam int LW = $clog2(MAX_BURST + 1),
    localparam int BW = LW + WORD_SH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tbl_we,
    input  logic [PW-1:0]     tbl_idx,
    input  logic [63:0]       tbl_data,
    input  logic [CW-1:0]     pg_cnt,
    input  logic [63:0]       loc_base,
    input  logic [PW-1:0]     host_page,
    input  logic [KW-1:0]     host_pkt,
    input  logic              brst_valid,
    output logic              brst_ready,
    input  logic [LW-1:0]     brst_words,
    input  logic              brst_last,
    output logic              dsc_valid,
    input  logic              dsc_ready,
    output logic [63:0]       dsc_addr,
    output logic [BW-1:0]     dsc_bytes,
    output logic [PW-1:0]     dsc_page,
    output logic [KW-1:0]     dsc_pkt,
    output logic              dsc_ovr,
    output logic              dsc_eop,
    output logic              loc_valid,
    input  logic              loc_ready,
    output logic [63:0]       loc_addr,
    output logic [PW-1:0]     loc_start_page,
    output logic [OW-1:0]     loc_start_off,
    output logic [PW-1:0]     loc_end_page,
    output logic [OW-1:0]     loc_end_off,
    output logic [PW-1:0]     cur_page,
    output logic [KW-1:0]     cur_pkt,
    output logic              ovr_flag
);
    logic          fire;
    logic [PW-1:0] tgt_page, sp;
    logic [OW-1:0] tgt_off, so, eo;
    logic          ovr;
    logic [63:0]   base;
    logic [63:0]   addr;
    logic [BW-1:0] bytes;

    assign fire  = brst_valid && brst_ready;
    assign addr  = word_addr(base, 32'(tgt_off));
    assign bytes = BW'(brst_words) << WORD_SH;

    sgc_page_table #(.NBUFS(NBUFS), .AW(ADDR_W)) u_table (
        .clk  (clk),
        .we   (tbl_we),
        .widx (tbl_idx),
        .wdata(tbl_data),
        .ridx (tgt_page),
        .rdata(base)
    );

    sgc_ring_track #(
        .NBUFS(NBUFS), .PAGE_WORDS(PAGE_WORDS),
        .PKT_SLOTS(PKT_SLOTS), .MAX_BURST(MAX_BURST)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .pg_cnt    (pg_cnt),
        .host_page (host_page),
        .host_pkt  (host_pkt),
        .cur_pkt   (cur_pkt),
        .words     (brst_words),
        .last      (brst_last),
        .fire      (fire),
        .tgt_page  (tgt_page),
        .tgt_off   (tgt_off),
        .ovr       (ovr),
        .start_page(sp),
        .start_off (so),
        .end_off   (eo),
        .cur_page  (cur_page)
    );

    sgc_out_stage #(
        .PW(PW), .OW(OW), .KW(KW), .BW(BW), .PKT_SLOTS(PKT_SLOTS)
    ) u_out (
        .clk           (clk),
        .rst           (rst),
        .fire          (fire),
        .in_addr       (addr),
        .in_bytes      (bytes),
        .in_page       (tgt_page),
        .in_ovr        (ovr),
        .in_eop        (brst_last),
        .in_sp         (sp),
        .in_so         (so),
        .in_eo         (eo),
        .loc_base      (loc_base),
        .brst_ready    (brst_ready),
        .dsc_valid     (dsc_valid),
        .dsc_ready     (dsc_ready),
        .dsc_addr      (dsc_addr),
        .dsc_bytes     (dsc_bytes),
        .dsc_page      (dsc_page),
        .dsc_pkt       (dsc_pkt),
        .dsc_ovr       (dsc_ovr),
        .dsc_eop       (dsc_eop),
        .loc_valid     (loc_valid),
        .loc_ready     (loc_ready),
        .loc_addr      (loc_addr),
        .loc_start_page(loc_start_page),
        .loc_start_off (loc_start_off),
        .loc_end_page  (loc_end_page),
        .loc_end_off   (loc_end_off),
        .cur_pkt       (cur_pkt),
        .ovr_flag      (ovr_flag)
    );

    assert_busy_gate_R8: assert property (@(posedge clk) disable iff (rst)
        loc_valid |-> !brst_ready);
endmodule

// File: tb/sgc_chunk_gen_tb.sv
`timescale 1ns/1ps
module sgc_chunk_gen_tb;
    localparam int NB = 8;
    localparam int PGB = 256;
    localparam int PWD = PGB / 32;
    localparam int SLOTS = 4;
    localparam int MB = 8;
    localparam int NPG = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tbl_we = 1'b0;
    logic [2:0] tbl_idx = '0;
    logic [63:0] tbl_data = '0;
    logic [3:0] pg_cnt = 4'(NPG);
    logic [63:0] loc_base = 64'h0000_00A0_0000_0000;
    logic [2:0] host_page = '0;
    logic [1:0] host_pkt = '0;
    logic brst_valid = 1'b0;
    logic brst_ready;
    logic [3:0] brst_words = 4'd1;
    logic brst_last = 1'b0;
    logic dsc_valid, dsc_ready, dsc_ovr, dsc_eop;
    logic [63:0] dsc_addr;
    logic [8:0] dsc_bytes;
    logic [2:0] dsc_page;
    logic [1:0] dsc_pkt;
    logic loc_valid, loc_ready;
    logic [63:0] loc_addr;
    logic [2:0] loc_start_page, loc_end_page, cur_page;
    logic [2:0] loc_start_off, loc_end_off;
    logic [1:0] cur_pkt;
    logic ovr_flag;

    always #4 clk = ~clk;

    sgc_chunk_gen #(.NBUFS(NB), .PAGE_BYTES(PGB), .PKT_SLOTS(SLOTS), .MAX_BURST(MB)) u_dut (
        .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
        .pg_cnt(pg_cnt), .loc_base(loc_base), .host_page(host_page), .host_pkt(host_pkt),
        .brst_valid(brst_valid), .brst_ready(brst_ready), .brst_words(brst_words),
        .brst_last(brst_last), .dsc_valid(dsc_valid), .dsc_ready(dsc_ready),
        .dsc_addr(dsc_addr), .dsc_bytes(dsc_bytes), .dsc_page(dsc_page), .dsc_pkt(dsc_pkt),
        .dsc_ovr(dsc_ovr), .dsc_eop(dsc_eop), .loc_valid(loc_valid), .loc_ready(loc_ready),
        .loc_addr(loc_addr), .loc_start_page(loc_start_page), .loc_start_off(loc_start_off),
        .loc_end_page(loc_end_page), .loc_end_off(loc_end_off), .cur_page(cur_page),
        .cur_pkt(cur_pkt), .ovr_flag(ovr_flag)
    );

    int total = 0;
    int bad = 0;
    logic [63:0] tbl_m [NB];
    int m_wp = 0, m_off = 0, m_pkt = 0, m_sp = 0, m_so = 0;
    bit m_full = 0, m_in = 0, m_stk = 0;
    bit last_ovr = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int nxt(input int i, input int n);
        return (i + 1 >= n) ? 0 : i + 1;
    endfunction

    function automatic int room();
        return m_full ? PWD : PWD - m_off;
    endfunction

    task automatic send(input int words, input bit last, input int dd, input int ld);
        int e_page, e_off, e_end, e_sp, e_so, old_pkt;
        bit e_ovr, rec;
        logic [63:0] e_addr;
        e_page = m_full ? nxt(m_wp, NPG) : m_wp;
        e_off  = m_full ? 0 : m_off;
        e_ovr  = (m_full && nxt(m_wp, NPG) == int'(host_page)) ||
                 (nxt(m_pkt, SLOTS) == int'(host_pkt));
        e_addr = tbl_m[e_page] + 64'(e_off * 32);
        e_end  = e_off + words - 1;
        e_sp   = m_in ? m_sp : e_page;
        e_so   = m_in ? m_so : e_off;
        rec    = last && !e_ovr;
        old_pkt = m_pkt;
        if (!e_ovr) begin
            m_wp = e_page;
            if (e_off + words >= PWD) begin m_full = 1; m_off = 0; end
            else begin m_full = 0; m_off = e_off + words; end
            if (!m_in) begin m_sp = e_page; m_so = e_off; end
            m_in = !last;
        end else if (last) m_in = 0;
        if (e_ovr) m_stk = 1;
        last_ovr = e_ovr;

        @(negedge clk);
        brst_words = 4'(words);
        brst_last = last;
        brst_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        brst_valid = 1'b0;
        chk("R8 desc raised", 64'(dsc_valid), 64'd1);
        chk("R2 address", dsc_addr, e_addr);
        chk("R4 bytes", 64'(dsc_bytes), 64'(words * 32));
        chk("R4 page", 64'(dsc_page), 64'(e_page));
        chk("R4 pkt", 64'(dsc_pkt), 64'(old_pkt));
        chk("R4 eop", 64'(dsc_eop), 64'(last));
        chk(e_ovr ? "R5 R6 overrun set" : "R5 R6 overrun clear", 64'(dsc_ovr), 64'(e_ovr));
        chk("R9 record raised", 64'(loc_valid), 64'(rec));
        chk("R3 cur_page", 64'(cur_page), 64'(m_wp));
        chk("R7 sticky", 64'(ovr_flag), 64'(m_stk));
        if (rec) begin
            chk("R9 loc addr", loc_addr, loc_base + 64'(old_pkt * 16));
            chk("R9 start page", 64'(loc_start_page), 64'(e_sp));
            chk("R9 start off", 64'(loc_start_off), 64'(e_so));
            chk("R9 end page", 64'(loc_end_page), 64'(e_page));
            chk("R9 end off", 64'(loc_end_off), 64'(e_end));
        end
        for (int c = 0; c < 32; c++) begin
            if (!dsc_valid && !loc_valid) break;
            if (c > 0) begin
                chk("R8 busy", 64'(brst_ready), 64'd0);
                chk("R9 pkt held", 64'(cur_pkt), 64'(old_pkt));
                if (dsc_valid) chk("R8 addr stable", dsc_addr, e_addr);
            end
            dsc_ready = dsc_valid && (c >= dd);
            loc_ready = loc_valid && (c >= ld);
            @(negedge clk);
        end
        dsc_ready = 1'b0;
        loc_ready = 1'b0;
        if (rec) m_pkt = nxt(m_pkt, SLOTS);
        chk("R8 ready again", 64'(brst_ready), 64'd1);
        chk("R9 pkt advance", 64'(cur_pkt), 64'(m_pkt));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int w;
        void'($urandom(32'd20231));
        dsc_ready = 1'b0;
        loc_ready = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 brst_ready", 64'(brst_ready), 64'd1);
        chk("R1 dsc_valid", 64'(dsc_valid), 64'd0);
        chk("R1 loc_valid", 64'(loc_valid), 64'd0);
        chk("R1 cur_page", 64'(cur_page), 64'd0);
        chk("R1 cur_pkt", 64'(cur_pkt), 64'd0);
        chk("R1 ovr_flag", 64'(ovr_flag), 64'd0);
        rst = 1'b0;
        for (int i = 0; i < NB; i++) begin
            tbl_m[i] = {$urandom(), $urandom()} & ~64'(PGB - 1);
            @(negedge clk);
            tbl_we = 1'b1;
            tbl_idx = 3'(i);
            tbl_data = tbl_m[i];
        end
        @(negedge clk);
        tbl_we = 1'b0;

        // random traffic with the host keeping up (R2 R3 R4 R9)
        for (int n = 0; n < 60; n++) begin
            host_page = 3'(m_wp);
            host_pkt = 2'(m_pkt);
            w = $urandom_range(1, room());
            send(w, $urandom_range(0, 2) == 0, $urandom_range(0, 3), $urandom_range(0, 3));
        end
        // close any open packet
        host_page = 3'(m_wp);
        host_pkt = 2'(m_pkt);
        send(1, 1, 0, 0);

        // R5: host holds its page, fill pages until blocked
        host_page = 3'(m_wp);
        host_pkt = 2'(m_pkt);
        for (int n = 0; n < 12; n++) begin
            send(room(), 0, 0, 0);
            if (last_ovr) break;
        end
        chk("R5 blocked reached", 64'(last_ovr), 64'd1);
        send(2, 1, 0, 0);
        chk("R5 eop dropped", 64'(last_ovr), 64'd1);
        // R10: release and retry
        host_page = 3'(m_wp);
        send(3, 1, 2, 0);
        chk("R10 resumed", 64'(last_ovr), 64'd0);

        // R6: host holds packet slots
        host_pkt = 2'(m_pkt);
        for (int n = 0; n < SLOTS + 1; n++) begin
            host_page = 3'(m_wp);
            send(1, 1, $urandom_range(0, 2), $urandom_range(0, 2));
            if (last_ovr) break;
        end
        chk("R6 slot block reached", 64'(last_ovr), 64'd1);
        host_pkt = 2'(m_pkt);
        host_page = 3'(m_wp);
        send(2, 1, 0, 3);
        chk("R6 resumed", 64'(last_ovr), 64'd0);

        // R2: rewrite a table entry and use it
        for (int n = 0; n < 20; n++) begin
            host_page = 3'(m_wp);
            host_pkt = 2'(m_pkt);
            if (n % 5 == 0) begin
                int p;
                p = m_full ? nxt(m_wp, NPG) : m_wp;
                tbl_m[p] = {$urandom(), $urandom()} & ~64'(PGB - 1);
                @(negedge clk);
                tbl_we = 1'b1; tbl_idx = 3'(p); tbl_data = tbl_m[p];
                @(negedge clk);
                tbl_we = 1'b0;
            end
            send($urandom_range(1, room()), $urandom_range(0, 1) == 1, 1, 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule